// File: doc/BRIEF.md
# Compressed Table-Jump Expander

This unit sits in the decode path of a 32-bit embedded core that runs without address translation. Each cycle it looks at the instruction leaving the compressed decoder. When that instruction is flagged as a table jump and is not illegal, the unit pulls an 8-bit table index out of it. It reads a 32-bit target word from the jump table held in memory, at the base given by a CSR plus four bytes per index. It then hands downstream a full-width JAL that branches to that target. Every other instruction flows through untouched, in the same cycle.

The memory read goes over a dedicated request/response port. The request follows valid/ready rules: once raised, `mem_req_valid_o` and `mem_req_addr_o` stay fixed until the cycle in which `mem_req_ready_i` is high, and that cycle is the grant. The response carries no back-pressure. The unit takes the data in the first cycle after the grant in which `mem_rsp_valid_i` is high. Fetch is stalled from the cycle the table jump is first seen until the cycle in which the generated jump is shown, so the upstream instruction stays in place throughout.

Small indices give a plain jump. Large indices give the linking form, which writes the return address into x1. The output keeps the compressed flag set, so the rest of the pipeline steps the PC and the link value by two bytes.

Top module: `tj_expand`

## Requirements
- R1: The table index is instruction bits [9:2], and the request address is the table base plus four times the index.
- R2: A raised request keeps its valid and address unchanged until the cycle in which ready is high.
- R3: Fetch stall is high from the first cycle a legal table jump is present, through the grant and response wait. It is low in the single cycle in which the generated jump is shown.
- R4: An index below 32 produces a jump with rd = x0. An index of 32 or more produces a jump with rd = x1.
- R5: The generated instruction is a JAL (opcode 1101111). Its 21-bit offset is the loaded target with bit 0 cleared, minus the PC of the table jump, placed in the standard JAL immediate bit positions.
- R6: An instruction not flagged as a table jump is forwarded with its bits and its illegal and compressed flags unchanged, in the same cycle. It raises no stall and no request.
- R7: A table jump that arrives flagged illegal is forwarded unchanged, like any other instruction, with no stall and no request.
- R8: While the generated jump is shown, the compressed flag is 1 and the illegal flag is 0.
- R9: A response valid that arrives before the grant has been given is ignored. The target used is the one returned after the grant.
- R10: While reset is asserted and after it is released, there is no request and no stall until a table jump arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction from the compressed decoder |
| pc_i | input | XLEN | PC of the incoming instruction |
| is_tj_i | input | 1 | Incoming instruction is a table jump |
| illegal_i | input | 1 | Incoming instruction is illegal |
| compressed_i | input | 1 | Incoming instruction was compressed |
| tbl_base_i | input | XLEN | Jump table base address from the CSR |
| mem_req_valid_o | output | 1 | Table read request valid |
| mem_req_ready_i | input | 1 | Table read request accepted |
| mem_req_addr_o | output | XLEN | Table entry address |
| mem_rsp_valid_i | input | 1 | Table read data valid |
| mem_rsp_data_i | input | 32 | Table read data (jump target) |
| instr_o | output | 32 | Instruction to the rest of decode |
| illegal_o | output | 1 | Outgoing illegal flag |
| compressed_o | output | 1 | Outgoing compressed flag |
| fetch_stall_o | output | 1 | Hold fetch |

## Verification
The bench sweeps all 256 indices, so both sides of the link boundary at 31 and 32 are covered. An off-by-one in the threshold would write x1 on a plain jump, or leave it unwritten on a linking one. Grant and response delays vary from zero to several cycles. Junk response strobes are sent while the request is still waiting for its grant. A design that latched too early would jump to the junk target, and one that let the address drift under back-pressure would read the wrong entry. Targets are spread forward and backward of the PC and carry bit 0 set, so a sign or immediate-scrambling mistake in the offset shows up as a wrong instruction word. A mixed sweep of pass-through traffic, including illegal table jumps and stray response strobes, catches any unit that stalls or rewrites what it should leave alone.

// File: rtl/tj_pkg.sv
package tj_pkg;

  localparam int unsigned INSTR_W = 32;
  localparam logic [6:0]  OPC_JAL = 7'b1101111;

  typedef enum logic [1:0] {
    TJ_IDLE = 2'd0,
    TJ_REQ  = 2'd1,
    TJ_WAIT = 2'd2,
    TJ_EMIT = 2'd3
  } tj_state_e;

  // Pack a 21-bit byte offset and rd into a JAL word.
  function automatic logic [INSTR_W-1:0] enc_jal(input logic [20:0] off,
                                                 input logic [4:0]  rd);
    return {off[20], off[10:1], off[11], off[19:12], rd, OPC_JAL};
  endfunction

endpackage

// File: rtl/tj_index_extract.sv
module tj_index_extract #(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned LINK_FROM = 32
) (
  input  logic [IDX_W-1:0] idx_field_i,
  input  logic [XLEN-1:0]  base_i,
  output logic [XLEN-1:0]  entry_addr_o,
  output logic             link_o
);
  localparam int unsigned ENTRY_SHIFT = 2;

  logic [XLEN-1:0] idx_ext;

  assign idx_ext      = XLEN'(idx_field_i);
  assign entry_addr_o = base_i + (idx_ext << ENTRY_SHIFT);
  assign link_o       = (idx_ext >= XLEN'(LINK_FROM));
endmodule

// File: rtl/tj_fetch_fsm.sv
module tj_fetch_fsm
  import tj_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [XLEN-1:0]     entry_addr_i,
  input  logic                link_i,
  input  logic [XLEN-1:0]     pc_i,
  input  logic                req_ready_i,
  input  logic                rsp_valid_i,
  input  logic [INSTR_W-1:0]  rsp_data_i,
  output tj_state_e           state_o,
  output logic                req_valid_o,
  output logic [XLEN-1:0]     req_addr_o,
  output logic [INSTR_W-1:0]  target_o,
  output logic [XLEN-1:0]     pc_o,
  output logic                link_o
);
  tj_state_e state_q, state_d;
  logic [XLEN-1:0]    addr_q;
  logic [XLEN-1:0]    pc_q;
  logic [INSTR_W-1:0] tgt_q;
  logic               link_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TJ_IDLE: if (start_i)     state_d = TJ_REQ;
      TJ_REQ:  if (req_ready_i) state_d = TJ_WAIT;
      TJ_WAIT: if (rsp_valid_i) state_d = TJ_EMIT;
      TJ_EMIT:                  state_d = TJ_IDLE;
      default:                  state_d = TJ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TJ_IDLE;
      addr_q  <= '0;
      pc_q    <= '0;
      tgt_q   <= '0;
      link_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == TJ_IDLE && start_i) begin
        addr_q <= entry_addr_i;
        pc_q   <= pc_i;
        link_q <= link_i;
      end
      if (state_q == TJ_WAIT && rsp_valid_i) tgt_q <= rsp_data_i;
    end
  end

  assign state_o     = state_q;
  assign req_valid_o = (state_q == TJ_REQ);
  assign req_addr_o  = addr_q;
  assign target_o    = tgt_q;
  assign pc_o        = pc_q;
  assign link_o      = link_q;
endmodule

// File: rtl/tj_jump_gen.sv
module tj_jump_gen
  import tj_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [INSTR_W-1:0] target_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic               link_i,
  output logic [INSTR_W-1:0] instr_o
);
  localparam logic [4:0] RD_NONE = 5'd0;
  localparam logic [4:0] RD_RA   = 5'd1;

  logic [XLEN-1:0] tgt_ext;
  logic [XLEN-1:0] off;

  assign tgt_ext = XLEN'(target_i) & ~XLEN'(1);
  assign off     = tgt_ext - pc_i;
  assign instr_o = enc_jal(off[20:0], link_i ? RD_RA : RD_NONE);
endmodule

// File: rtl/tj_expand.sv
module tj_expand
  import tj_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned IDX_LSB   = 2,
  parameter int unsigned LINK_FROM = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [31:0]        instr_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic               is_tj_i,
  input  logic               illegal_i,
  input  logic               compressed_i,
  input  logic [XLEN-1:0]    tbl_base_i,
  output logic               mem_req_valid_o,
  input  logic               mem_req_ready_i,
  output logic [XLEN-1:0]    mem_req_addr_o,
  input  logic               mem_rsp_valid_i,
  input  logic [31:0]        mem_rsp_data_i,
  output logic [31:0]        instr_o,
  output logic               illegal_o,
  output logic               compressed_o,
  output logic               fetch_stall_o
);
  tj_state_e          state;
  logic               start;
  logic [XLEN-1:0]    entry_addr;
  logic               link_new, link_held;
  logic [INSTR_W-1:0] target;
  logic [XLEN-1:0]    pc_held;
  logic [INSTR_W-1:0] jump_word;
  logic               emit;

  tj_index_extract #(.XLEN(XLEN), .IDX_W(IDX_W), .LINK_FROM(LINK_FROM)) u_idx (
    .idx_field_i (instr_i[IDX_LSB +: IDX_W]),
    .base_i      (tbl_base_i),
    .entry_addr_o(entry_addr),
    .link_o      (link_new)
  );

  assign start = (state == TJ_IDLE) && is_tj_i && !illegal_i;

  tj_fetch_fsm #(.XLEN(XLEN)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .entry_addr_i(entry_addr),
    .link_i      (link_new),
    .pc_i        (pc_i),
    .req_ready_i (mem_req_ready_i),
    .rsp_valid_i (mem_rsp_valid_i),
    .rsp_data_i  (mem_rsp_data_i),
    .state_o     (state),
    .req_valid_o (mem_req_valid_o),
    .req_addr_o  (mem_req_addr_o),
    .target_o    (target),
    .pc_o        (pc_held),
    .link_o      (link_held)
  );

  tj_jump_gen #(.XLEN(XLEN)) u_gen (
    .target_i(target),
    .pc_i    (pc_held),
    .link_i  (link_held),
    .instr_o (jump_word)
  );

  assign emit          = (state == TJ_EMIT);
  assign fetch_stall_o = start || (state == TJ_REQ) || (state == TJ_WAIT);
  assign instr_o       = emit ? jump_word : instr_i;
  assign illegal_o     = emit ? 1'b0 : illegal_i;
  assign compressed_o  = emit ? 1'b1 : compressed_i;
endmodule

// File: rtl/tj_expand_chk.sv
module tj_expand_chk
  import tj_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input tj_state_e       state,
  input logic            illegal_i,
  input logic            mem_req_valid_o,
  input logic            mem_req_ready_i,
  input logic [XLEN-1:0] mem_req_addr_o,
  input logic            mem_rsp_valid_i,
  input logic [31:0]     instr_o,
  input logic            illegal_o,
  input logic            compressed_o,
  input logic            fetch_stall_o
);
  a_r2_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  a_r3_stall_with_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> fetch_stall_o);

  a_r3_release_on_emit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == TJ_WAIT && mem_rsp_valid_i) |=> (!fetch_stall_o && instr_o[6:0] == OPC_JAL));

  a_r6_idle_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == TJ_IDLE) |-> !mem_req_valid_o);

  a_r7_illegal_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == TJ_IDLE && illegal_i) |-> !fetch_stall_o);

  a_r8_emit_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == TJ_EMIT) |-> (compressed_o && !illegal_o));

  always_comb begin
    if (!rst_ni) a_r10_reset_quiet: assert (!mem_req_valid_o && !fetch_stall_o);
  end
endmodule

bind tj_expand tj_expand_chk #(.XLEN(XLEN)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .state          (state),
  .illegal_i      (illegal_i),
  .mem_req_valid_o(mem_req_valid_o),
  .mem_req_ready_i(mem_req_ready_i),
  .mem_req_addr_o (mem_req_addr_o),
  .mem_rsp_valid_i(mem_rsp_valid_i),
  .instr_o        (instr_o),
  .illegal_o      (illegal_o),
  .compressed_o   (compressed_o),
  .fetch_stall_o  (fetch_stall_o)
);

// File: tb/sim_tj_expand.sv
module sim_tj_expand;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [31:0]     instr = 32'h13;
  logic [XLEN-1:0] pc = '0;
  logic            is_tj = 1'b0, ill = 1'b0, comp = 1'b0;
  logic [XLEN-1:0] base = '0;
  logic            req_valid, req_ready = 1'b0;
  logic [XLEN-1:0] req_addr;
  logic            rsp_valid = 1'b0;
  logic [31:0]     rsp_data = '0;
  logic [31:0]     instr_out;
  logic            ill_out, comp_out, stall;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  tj_expand u0 (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .pc_i(pc), .is_tj_i(is_tj),
    .illegal_i(ill), .compressed_i(comp), .tbl_base_i(base),
    .mem_req_valid_o(req_valid), .mem_req_ready_i(req_ready), .mem_req_addr_o(req_addr),
    .mem_rsp_valid_i(rsp_valid), .mem_rsp_data_i(rsp_data),
    .instr_o(instr_out), .illegal_o(ill_out), .compressed_o(comp_out), .fetch_stall_o(stall)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_jal(input logic [31:0] tgt, input logic [31:0] p,
                                          input int idx);
    logic [31:0] d;
    logic [4:0]  rd;
    d  = {tgt[31:1], 1'b0} - p;
    rd = (idx >= 32) ? 5'd1 : 5'd0;
    return {d[20], d[10:1], d[11], d[19:12], rd, 7'b1101111};
  endfunction

  task automatic do_tj(input int idx, input logic [31:0] p, input logic [31:0] b,
                       input logic [31:0] tgt, input int gd, input int rdly);
    @(negedge clk);
    instr = {16'h0, 3'b101, 3'b000, idx[7:0], 2'b10};
    is_tj = 1'b1; ill = 1'b0; comp = 1'b1; pc = p; base = b;
    #1 chk("R3 stall on arrival", {31'b0, stall}, 32'd1);
    @(negedge clk);
    for (int g = 0; g < gd; g++) begin
      #1;
      chk("R2 req held", {31'b0, req_valid}, 32'd1);
      chk("R1 entry address", req_addr, b + 32'(idx) * 4);
      chk("R3 stall during grant wait", {31'b0, stall}, 32'd1);
      rsp_valid = 1'b1; rsp_data = ~tgt;  // R9: early strobe must be ignored
      @(negedge clk);
      rsp_valid = 1'b0;
    end
    #1;
    chk("R1 entry address at grant", req_addr, b + 32'(idx) * 4);
    chk("R2 req valid at grant", {31'b0, req_valid}, 32'd1);
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    for (int r = 0; r < rdly; r++) begin
      #1;
      chk("R3 stall during response wait", {31'b0, stall}, 32'd1);
      chk("R2 request dropped after grant", {31'b0, req_valid}, 32'd0);
      @(negedge clk);
    end
    rsp_valid = 1'b1; rsp_data = tgt;
    @(negedge clk);
    rsp_valid = 1'b0; rsp_data = '0;
    #1;
    chk("R4 R5 R9 generated jump", instr_out, exp_jal(tgt, p, idx));
    chk("R3 stall low on emit", {31'b0, stall}, 32'd0);
    chk("R8 flags on emit", {30'b0, comp_out, ill_out}, 32'b10);
    is_tj = 1'b0; instr = 32'h13; comp = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin : main
    // R10: quiet during and after reset
    #3;
    chk("R10 no stall in reset", {31'b0, stall}, 32'd0);
    chk("R10 no req in reset", {31'b0, req_valid}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R10 no stall after reset", {31'b0, stall}, 32'd0);
    chk("R10 no req after reset", {31'b0, req_valid}, 32'd0);

    // R1 R4 R5 R9: every index, varied delays and targets
    for (int i = 0; i < 256; i++) begin
      logic [31:0] p, b, t, off;
      p   = 32'h0001_0000 + 32'(i) * 32'h2A6;
      b   = 32'h0008_0000 + 32'(i % 7) * 32'h40;
      off = ((32'(i) * 32'h9E37_79B1) & 32'h001F_FFFE) - 32'h0010_0000;
      t   = p + off + 32'(i & 1);
      do_tj(i, p, b, t, i % 4, (i / 4) % 3);
    end

    // R6 R7: pass-through, including illegal table jumps and stray strobes
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      instr     = 32'(i) * 32'h9E37_79B9 + 32'h1234;
      is_tj     = (i % 5 == 0);
      ill       = is_tj ? 1'b1 : i[0];
      comp      = i[1];
      rsp_valid = i[2];
      rsp_data  = 32'hDEAD_0000 + 32'(i);
      #1;
      chk(is_tj ? "R7 illegal tj instr" : "R6 pass instr", instr_out, instr);
      chk(is_tj ? "R7 illegal tj flags" : "R6 pass flags",
          {30'b0, comp_out, ill_out}, {30'b0, comp, ill});
      chk(is_tj ? "R7 no stall" : "R6 no stall", {31'b0, stall}, 32'd0);
      chk(is_tj ? "R7 no req" : "R6 no req", {31'b0, req_valid}, 32'd0);
    end
    @(negedge clk);
    rsp_valid = 1'b0; is_tj = 1'b0; ill = 1'b0;
    @(negedge clk); #1;
    chk("R6 idle after pass sweep", {31'b0, stall || req_valid}, 32'd0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule